// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address for a four-beat burst into a synchronous memory. When an access starts, it captures a base address. The upper bits of that address stay fixed for the rest of the burst. Only the two lowest bits are sequenced, and each advance strobe moves them on by one beat. The burst wraps back to its starting beat after the fourth beat. When the advance strobe is low, the burst is suspended and the address holds.

Two orders are supported, and the order is chosen when the burst is loaded:

- **Linear order:** each beat is the start value plus a beat count, modulo the burst length.
- **Interleaved order:** each beat is the start value XOR the beat count.

Internally the sequencer keeps a beat counter. The output address is registered.

A memory controller drives `load_i` on the first cycle of an access, together with the address. It then strobes `step_i` once for each further beat it wants. A new load at any point starts a fresh burst from the new base.

Top module: `burst_addr_seq`

## Requirements
- R1: A cycle with `rst` high sets `addr_o` to all zeros on the next clock edge, which starts a burst at base zero in linear order.
- R2: When `load_i` is high at a clock edge, `addr_o` equals `base_i` after that edge and the beat count restarts at zero. This applies in the middle of a burst too.
- R3: When `load_i` and `step_i` are both high at the same edge, the load wins and `addr_o` equals `base_i`.
- R4: The bits of `addr_o` above bit 1 stay equal to the upper bits of the last loaded base until the next load or reset.
- R5: With `order_i` = 0 at load (linear order), beat n of the burst has low bits (start + n) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R6: With `order_i` = 1 at load (interleaved order), beat n of the burst has low bits start XOR n. For example, start 10 gives 10, 11, 00, 01.
- R7: When `step_i` and `load_i` are both low at an edge, `addr_o` holds its value (suspend).
- R8: The advance after the fourth beat returns the low bits to the start value, and the sequence repeats.
- R9: `order_i` is sampled only at load. Changing it during a burst does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Start a burst at `base_i` |
| step_i | input | 1 | Advance to the next beat (active high) |
| order_i | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| base_i | input | ADDR_W | Base address captured on load |
| addr_o | output | ADDR_W | Registered burst address |

## Verification
A corrupted beat counter shows up in `addr_o` one edge after the next advance, as a low-bit value outside the expected order. It also shows up at the wrap point, where the address fails to return to the start value after four advances. A wrongly captured start value, upper field or order shows up right after the load edge, or on the first advance. A hold fault shows up as `addr_o` changing across a suspend cycle. Each of these faults is visible within one or two cycles of the stimulus that exposes it.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

  // Map a start value and a beat count onto the sequenced low bits.
  function automatic logic [7:0] beat_map(input logic [7:0] start_v,
                                          input logic [7:0] beat_v,
                                          input order_e     ord,
                                          input int unsigned width);
    logic [7:0] raw;
    logic [7:0] mask;
    mask = 8'((9'd1 << width) - 9'd1);
    raw  = (ord == ORDER_XOR) ? (start_v ^ beat_v) : (start_v + beat_v);
    return raw & mask;
  endfunction
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_i,
  input  logic [ADDR_W-1:0]         base_i,
  input  logic                      order_i,
  output logic [ADDR_W-BURST_W-1:0] upper_nxt,
  output logic [BURST_W-1:0]        start_nxt,
  output order_e                    order_nxt
);
  localparam int UP_W = ADDR_W - BURST_W;

  logic [UP_W-1:0]    upper_q;
  logic [BURST_W-1:0] start_q;
  order_e             order_q;

  always_comb begin
    if (load_i) begin
      upper_nxt = base_i[ADDR_W-1:BURST_W];
      start_nxt = base_i[BURST_W-1:0];
      order_nxt = order_e'(order_i);
    end else begin
      upper_nxt = upper_q;
      start_nxt = start_q;
      order_nxt = order_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      start_q <= '0;
      order_q <= ORDER_LINEAR;
    end else begin
      upper_q <= upper_nxt;
      start_q <= start_nxt;
      order_q <= order_nxt;
    end
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               step_i,
  output logic [BURST_W-1:0] beat_nxt
);
  logic [BURST_W-1:0] beat_q;

  always_comb begin
    if (load_i)      beat_nxt = '0;
    else if (step_i) beat_nxt = beat_q + 1'b1;
    else             beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_seq_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] beat_i,
  input  order_e             order_i,
  output logic [BURST_W-1:0] low_o
);
  generate
    if (BURST_W == 1) begin : g_single
      assign low_o = start_i ^ beat_i;
    end else begin : g_multi
      logic [7:0] mapped;
      assign mapped = beat_map(8'(start_i), 8'(beat_i), order_i, BURST_W);
      assign low_o  = mapped[BURST_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - BURST_W;

  logic [UP_W-1:0]    upper_nxt;
  logic [BURST_W-1:0] start_nxt;
  logic [BURST_W-1:0] beat_nxt;
  logic [BURST_W-1:0] low_nxt;
  order_e             order_nxt;

  burst_base_reg #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_base (
    .clk(clk), .rst(rst), .load_i(load_i), .base_i(base_i),
    .order_i(order_i), .upper_nxt(upper_nxt), .start_nxt(start_nxt),
    .order_nxt(order_nxt)
  );

  burst_beat_cnt #(.BURST_W(BURST_W)) u_beat (
    .clk(clk), .rst(rst), .load_i(load_i), .step_i(step_i),
    .beat_nxt(beat_nxt)
  );

  burst_low_map #(.BURST_W(BURST_W)) u_map (
    .start_i(start_nxt), .beat_i(beat_nxt), .order_i(order_nxt),
    .low_o(low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_o <= '0;
    else     addr_o <= {upper_nxt, low_nxt};
  end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic              step_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] addr_o
);
  localparam int BEATS = 1 << BURST_W;

  logic [BURST_W-1:0] ref_start_q;
  logic [BURST_W:0]   steps_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_start_q <= '0;
      steps_q     <= '0;
    end else if (load_i) begin
      ref_start_q <= base_i[BURST_W-1:0];
      steps_q     <= '0;
    end else if (step_i) begin
      steps_q <= (steps_q == (BURST_W+1)'(BEATS-1)) ? '0 : steps_q + 1'b1;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> addr_o == '0);

  // R2
  load_base_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> addr_o == $past(base_i));

  // R4
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> addr_o[ADDR_W-1:BURST_W] == $past(addr_o[ADDR_W-1:BURST_W]));

  // R7
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(addr_o));

  // R5
  step_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && step_i) |=> addr_o[BURST_W-1:0] != $past(addr_o[BURST_W-1:0]));

  // R8
  wrap_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && step_i && steps_q == (BURST_W+1)'(BEATS-1))
      |=> addr_o[BURST_W-1:0] == $past(ref_start_q));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .step_i(step_i),
  .base_i(base_i), .addr_o(addr_o)
);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_i = 1'b0;
  logic          step_i = 1'b0;
  logic          order_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [AW-1:0] addr_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_W(2)) dut_i (
    .clk(clk), .rst(rst), .load_i(load_i), .step_i(step_i),
    .order_i(order_i), .base_i(base_i), .addr_o(addr_o)
  );

  // Each entry: {order, upper[12:0], s0..s5}. Beat s0 is the start; s4/s5 show the wrap.
  localparam logic [25:0] VEC [8] = '{
    {1'b0, 13'h0123, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b0, 13'h1F0A, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b0, 13'h0555, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b0, 13'h1AAA, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b1, 13'h0042, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b1, 13'h1234, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0},
    {1'b1, 13'h0F0F, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b1, 13'h1FFF, 2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 2'd2}
  };

  task automatic tick(input logic ld, input logic st, input logic [AW-1:0] b,
                      input logic ord);
    load_i  = ld;
    step_i  = st;
    base_i  = b;
    order_i = ord;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [AW-1:0] exp);
    total++;
    if (addr_o !== exp) begin
      bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: addr_o=%h expected=finish", addr_o);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    rst = 1'b1;
    tick(1'b0, 1'b0, 15'h7FFF, 1'b1);
    tick(1'b0, 1'b0, 15'h7FFF, 1'b1);
    check("R1 reset", '0);
    rst = 1'b0;
    // R1: after reset a burst runs from base 0 in linear order
    tick(1'b0, 1'b1, '0, 1'b1);
    check("R1 post-reset step", 15'd1);

    // Table walk: R2, R4, R5, R6, R7, R8, R9
    for (int i = 0; i < 8; i++) begin
      logic          ord;
      logic [12:0]   up;
      logic [AW-1:0] b;
      ord = VEC[i][25];
      up  = VEC[i][24:12];
      b   = {up, VEC[i][11:10]};
      tick(1'b1, 1'b0, b, ord);
      check("R2 load", b);
      for (int k = 1; k < 6; k++) begin
        // R9: flip order_i and drive junk on base_i during the burst
        tick(1'b0, 1'b1, ~b, ~ord);
        check(k >= 4 ? "R8 wrap" : (ord ? "R6 interleaved" : "R5 linear"),
              {up, VEC[i][11-2*k -: 2]});
        if (k == 2) begin
          tick(1'b0, 1'b0, ~b, ~ord);
          check("R7 suspend", {up, VEC[i][11-2*k -: 2]});
          tick(1'b0, 1'b0, b, ord);
          check("R4 upper hold", {up, VEC[i][11-2*k -: 2]});
        end
      end
    end

    // R3: load and step in the same cycle
    tick(1'b1, 1'b0, 15'h1235, 1'b0);
    tick(1'b0, 1'b1, '0, 1'b0);
    tick(1'b1, 1'b1, 15'h4562, 1'b1);
    check("R3 load priority", 15'h4562);
    tick(1'b0, 1'b1, '0, 1'b0);
    check("R3 then R6 next beat", 15'h4563);

    // R2: reload in the middle of a burst
    tick(1'b1, 1'b0, 15'h0F01, 1'b0);
    tick(1'b0, 1'b1, '0, 1'b0);
    check("R5 mid", 15'h0F02);
    tick(1'b1, 1'b0, 15'h3003, 1'b1);
    check("R2 reload", 15'h3003);
    tick(1'b0, 1'b1, '0, 1'b0);
    check("R6 after reload", 15'h3002);

    // R1: reset in the middle of a burst
    rst = 1'b1;
    tick(1'b0, 1'b1, '0, 1'b1);
    check("R1 mid reset", '0);
    rst = 1'b0;
    tick(1'b0, 1'b0, '0, 1'b0);
    check("R7 hold after reset", '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule